// File: doc/BRIEF.md
# Configuration Request Generator

This block lets host software run one configuration access at a time from a small register set. Software loads a target address (bus, device, function and register offset), optionally loads a payload into the data register, and then writes a control word with its send bit set. For a target on another bus the engine issues a single request on a request port. It waits for one completion and either captures the returned data or records why the access failed.

Accesses that name the root bus never leave the block. Device 0 on the root bus reaches a small local header array held inside the engine. Byte and halfword accesses to that array are merged into, or extracted from, the addressed dword. Any other device number on the root bus is refused at once. A programmable cycle limit bounds the wait for a completion. Every failed read leaves all ones in the data register, and each error cause is latched in a flag that software clears by writing a one to it.

Top module: `cfgr_engine`

## Requirements
- R1: The target address register holds the bus number in bits 31:24, the device in bits 23:19, the function in bits 18:16 and the byte offset in bits 11:0. The request address presented on `req_addr` is this value with bits 1:0 forced to zero.
- R2: A control write (select 1) with bit 31 set, made while idle to a bus other than the root bus, raises `req_valid` for exactly one cycle after the write edge. With it come `req_type1` taken from control bit 8, `req_write` taken from control bit 4, and `req_data` equal to the data register.
- R3: A control write with bit 31 clear issues no request. Writing zero to the control register reads back as zero.
- R4: Status bit 0 (busy) is set from the edge that issues a request until the edge that takes its completion or its timeout. Writes to the target address register while busy are ignored.
- R5: A completion with status 0 (success) ends a read by loading `cpl_data` into the data register (select 2).
- R6: A completion with status 1 sets status bit 4. A completion with status 2 or 3 sets status bit 5. Writing ones to status bits 7:4 (select 3) clears those bits.
- R7: A read that fails for any reason leaves 32'hFFFFFFFF in the data register. A failed write leaves the data register unchanged.
- R8: When no completion arrives within the number of cycles held in the timeout register (select 4, reset 1000), the engine sets status bit 6 and returns to idle.
- R9: On the root bus, an access to a nonzero device issues no request and sets status bit 7.
- R10: On the root bus, an access to device 0 reads or writes the local header array without issuing a request. Dwords beyond the array read as zero.
- R11: Control bits 1:0 give the local access size: 0 for a byte, 1 for a halfword, 2 or 3 for a dword. A byte or halfword write replaces only the lanes selected by offset bits 1:0 (bit 1 for a halfword) and keeps the other lanes.
- R12: A byte or halfword read of the local header returns the selected lanes shifted down to bit 0, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 address, 1 control, 2 data, 3 status, 4 timeout |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read value of the selected register |
| req_valid | output | 1 | One-cycle request strobe |
| req_type1 | output | 1 | Request is Type 1 |
| req_write | output | 1 | Request is a write |
| req_addr | output | 32 | Request target address, dword aligned |
| req_data | output | 32 | Write payload |
| cpl_valid | input | 1 | Completion strobe |
| cpl_status | input | 2 | 0 success, 1 unsupported request, 2 or 3 abort |
| cpl_data | input | 32 | Completion read data |

## Verification
A corrupted busy state shows up on the very next register read. It either leaves a second request strobe or a stale status bit 0, or it lets an address write land mid-access, which the address readback exposes one cycle later. A wrong lane shift or byte mask in the local header shows up the first time the merged dword is read back whole. An off-by-one in the timeout counter moves the clearing of busy by one cycle. The bench samples at exactly the expected cycle, so that shift is caught.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;
  typedef enum logic [2:0] {
    RG_TADDR = 3'd0,
    RG_CTRL  = 3'd1,
    RG_DATA  = 3'd2,
    RG_STAT  = 3'd3,
    RG_TMO   = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  localparam logic [1:0] CPL_OK = 2'd0;
  localparam logic [1:0] CPL_UR = 2'd1;

  localparam int CTL_SEND = 31;
  localparam int CTL_T1   = 8;
  localparam int CTL_WR   = 4;

  localparam int ST_BUSY = 0;
  localparam int ST_UR   = 4;
  localparam int ST_CA   = 5;
  localparam int ST_TO   = 6;
  localparam int ST_DNF  = 7;
endpackage

// File: rtl/cfgr_timeout.sv
module cfgr_timeout #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + (CW+1)'(1);
  assign expired = run && (cnt_inc >= {1'b0, limit});

  always_comb begin
    cnt_d = cnt_q;
    if (restart)  cnt_d = '0;
    else if (run) cnt_d = cnt_inc[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (restart || run) cnt_q <= cnt_d;
  end

  // R8: the limit is never passed while the counter keeps running
  assert_tmo_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && limit != '0) |-> (cnt_q < limit));
endmodule

// File: rtl/cfgr_local_hdr.sv
module cfgr_local_hdr
  import cfgr_pkg::*;
#(
  parameter int NDW  = 16,
  parameter int OFFW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_en,
  input  logic            acc_wr,
  input  logic [1:0]      acc_size,
  input  logic [OFFW-1:0] acc_off,
  input  logic [31:0]     acc_wdata,
  output logic [31:0]     acc_rdata
);
  localparam int IW = (NDW > 1) ? $clog2(NDW) : 1;
  localparam logic [OFFW-3:0] NDW_V = (OFFW-2)'(NDW);

  logic [31:0]     mem_q [NDW];
  logic [NDW-1:0]  wr_sel;
  logic            in_range;
  logic [IW-1:0]   idx;
  logic [4:0]      sh;
  logic [31:0]     lane_mask;
  logic [31:0]     wmask;
  logic [31:0]     cur_word;
  logic [31:0]     merged;
  logic            we;

  assign in_range = acc_off[OFFW-1:2] < NDW_V;
  assign idx      = acc_off[IW+1:2];
  assign we       = acc_en && acc_wr && in_range;

  always_comb begin
    case (acc_size)
      SZ_BYTE: begin sh = {acc_off[1:0], 3'b000}; lane_mask = 32'h0000_00FF; end
      SZ_HALF: begin sh = {acc_off[1], 4'b0000};  lane_mask = 32'h0000_FFFF; end
      default: begin sh = 5'd0;                   lane_mask = 32'hFFFF_FFFF; end
    endcase
  end

  assign wmask     = lane_mask << sh;
  assign cur_word  = in_range ? mem_q[idx] : 32'h0;
  assign merged    = (cur_word & ~wmask) | ((acc_wdata << sh) & wmask);
  assign acc_rdata = (cur_word >> sh) & lane_mask;

  for (genvar g = 0; g < NDW; g++) begin : g_sel
    assign wr_sel[g] = we && (idx == IW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NDW; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < NDW; i++)
        if (wr_sel[i]) mem_q[i] <= merged;
    end
  end

  // R11: a write that does not cover the top lane leaves it untouched
  assert_lane_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wmask[31]) |=> (mem_q[$past(idx)][31:24] == $past(cur_word[31:24])));
endmodule

// File: rtl/cfgr_engine.sv
module cfgr_engine
  import cfgr_pkg::*;
#(
  parameter logic [7:0] ROOT_BUS   = 8'h00,
  parameter int         HDR_DWORDS = 16,
  parameter int         TMO_W      = 20,
  parameter int         TMO_INIT   = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        req_valid,
  output logic        req_type1,
  output logic        req_write,
  output logic [31:0] req_addr,
  output logic [31:0] req_data,
  input  logic        cpl_valid,
  input  logic [1:0]  cpl_status,
  input  logic [31:0] cpl_data
);
  localparam int OFFW = 12;

  logic [31:0]      taddr_q, taddr_d;
  logic [31:0]      ctl_q, ctl_d;
  logic [31:0]      data_q, data_d;
  logic [TMO_W-1:0] tmo_q, tmo_d;
  logic             busy_q, busy_d;
  logic             ur_q, ca_q, to_q, dnf_q;
  logic             ur_d, ca_d, to_d, dnf_d;
  logic             rv_q, rt1_q, rwr_q;
  logic [31:0]      raddr_q, rdata_q;

  logic wr_taddr, wr_ctrl, wr_data, wr_stat, wr_tmo;
  logic start, is_root, local_go, dnf_go, remote_go;
  logic tmo_exp, tmo_hit, cpl_take, cpl_ok;
  logic [31:0] hdr_rdata;

  assign wr_taddr = reg_we && (reg_sel == RG_TADDR) && !busy_q;
  assign wr_ctrl  = reg_we && (reg_sel == RG_CTRL)  && !busy_q;
  assign wr_data  = reg_we && (reg_sel == RG_DATA);
  assign wr_stat  = reg_we && (reg_sel == RG_STAT);
  assign wr_tmo   = reg_we && (reg_sel == RG_TMO);

  assign start     = wr_ctrl && reg_wdata[CTL_SEND];
  assign is_root   = (taddr_q[31:24] == ROOT_BUS);
  assign local_go  = start && is_root && (taddr_q[23:19] == 5'd0);
  assign dnf_go    = start && is_root && (taddr_q[23:19] != 5'd0);
  assign remote_go = start && !is_root;

  assign cpl_take = busy_q && cpl_valid;
  assign cpl_ok   = (cpl_status == CPL_OK);
  assign tmo_hit  = tmo_exp && !cpl_valid;

  cfgr_timeout #(.CW(TMO_W)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (remote_go),
    .run     (busy_q),
    .limit   (tmo_q),
    .expired (tmo_exp)
  );

  cfgr_local_hdr #(.NDW(HDR_DWORDS), .OFFW(OFFW)) u_hdr (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (local_go),
    .acc_wr    (reg_wdata[CTL_WR]),
    .acc_size  (reg_wdata[1:0]),
    .acc_off   (taddr_q[OFFW-1:0]),
    .acc_wdata (data_q),
    .acc_rdata (hdr_rdata)
  );

  // next state
  always_comb begin
    taddr_d = wr_taddr ? reg_wdata : taddr_q;
    ctl_d   = wr_ctrl  ? reg_wdata : ctl_q;
    tmo_d   = wr_tmo   ? reg_wdata[TMO_W-1:0] : tmo_q;

    busy_d = busy_q;
    if (remote_go)                 busy_d = 1'b1;
    else if (cpl_take || tmo_hit)  busy_d = 1'b0;

    data_d = data_q;
    if (wr_data) data_d = reg_wdata;
    if (local_go && !reg_wdata[CTL_WR])      data_d = hdr_rdata;
    if (dnf_go && !reg_wdata[CTL_WR])        data_d = 32'hFFFF_FFFF;
    if (cpl_take && !rwr_q)                  data_d = cpl_ok ? cpl_data : 32'hFFFF_FFFF;
    if (busy_q && tmo_hit && !rwr_q)         data_d = 32'hFFFF_FFFF;

    ur_d  = (ur_q  && !(wr_stat && reg_wdata[ST_UR]))  || (cpl_take && cpl_status == CPL_UR);
    ca_d  = (ca_q  && !(wr_stat && reg_wdata[ST_CA]))  || (cpl_take && cpl_status[1]);
    to_d  = (to_q  && !(wr_stat && reg_wdata[ST_TO]))  || (busy_q && tmo_hit);
    dnf_d = (dnf_q && !(wr_stat && reg_wdata[ST_DNF])) || dnf_go;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taddr_q <= '0;
      ctl_q   <= '0;
      data_q  <= '0;
      tmo_q   <= TMO_W'(TMO_INIT);
      busy_q  <= 1'b0;
      ur_q    <= 1'b0;
      ca_q    <= 1'b0;
      to_q    <= 1'b0;
      dnf_q   <= 1'b0;
      rv_q    <= 1'b0;
      rt1_q   <= 1'b0;
      rwr_q   <= 1'b0;
      raddr_q <= '0;
      rdata_q <= '0;
    end else begin
      taddr_q <= taddr_d;
      ctl_q   <= ctl_d;
      data_q  <= data_d;
      tmo_q   <= tmo_d;
      busy_q  <= busy_d;
      ur_q    <= ur_d;
      ca_q    <= ca_d;
      to_q    <= to_d;
      dnf_q   <= dnf_d;
      rv_q    <= remote_go;
      if (remote_go) begin
        rt1_q   <= reg_wdata[CTL_T1];
        rwr_q   <= reg_wdata[CTL_WR];
        raddr_q <= {taddr_q[31:2], 2'b00};
        rdata_q <= data_q;
      end
    end
  end

  always_comb begin
    case (reg_sel)
      RG_TADDR: reg_rdata = taddr_q;
      RG_CTRL:  reg_rdata = ctl_q;
      RG_DATA:  reg_rdata = data_q;
      RG_STAT:  reg_rdata = {24'h0, dnf_q, to_q, ca_q, ur_q, 3'b000, busy_q};
      RG_TMO:   reg_rdata = {{(32-TMO_W){1'b0}}, tmo_q};
      default:  reg_rdata = 32'h0;
    endcase
  end

  assign req_valid = rv_q;
  assign req_type1 = rt1_q;
  assign req_write = rwr_q;
  assign req_addr  = raddr_q;
  assign req_data  = rdata_q;

  // R2: one strobe per access
  assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  // R4: a strobe only while the access is outstanding
  assert_req_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy_q);
  // R4: target address frozen during an access
  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(taddr_q));
  // R5: a completion ends the access
  assert_cpl_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cpl_valid) |=> !busy_q);
  // R8: a timed-out read returns all ones
  assert_tmo_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && tmo_hit && !rwr_q) |=> (data_q == 32'hFFFF_FFFF) && to_q);
  // R9: a refused root-bus access sends nothing
  assert_dnf_noreq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dnf_go |=> !req_valid && dnf_q);
endmodule

// File: tb/sim_cfgr_engine.sv
module sim_cfgr_engine;
  logic        clk, rst_n;
  logic        reg_we;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic        req_valid, req_type1, req_write;
  logic [31:0] req_addr, req_data;
  logic        cpl_valid;
  logic [1:0]  cpl_status;
  logic [31:0] cpl_data;

  int n_chk = 0;
  int n_bad = 0;
  int req_cnt = 0;
  bit done = 0;

  cfgr_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_type1(req_type1), .req_write(req_write), .req_addr(req_addr),
    .req_data(req_data), .cpl_valid(cpl_valid), .cpl_status(cpl_status),
    .cpl_data(cpl_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) if (rst_n && req_valid) req_cnt++;

  typedef struct packed {
    logic        wr;
    logic [1:0]  size;
    logic [11:0] off;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'd2, 12'h008, 32'hA1B2C3D4, 32'h0},
    '{1'b0, 2'd2, 12'h008, 32'h0,        32'hA1B2C3D4},
    '{1'b1, 2'd0, 12'h009, 32'h000000EE, 32'h0},
    '{1'b0, 2'd2, 12'h008, 32'h0,        32'hA1B2EED4},
    '{1'b1, 2'd1, 12'h00A, 32'h00001234, 32'h0},
    '{1'b0, 2'd2, 12'h008, 32'h0,        32'h1234EED4},
    '{1'b0, 2'd0, 12'h00B, 32'h0,        32'h00000012},
    '{1'b0, 2'd1, 12'h008, 32'h0,        32'h0000EED4},
    '{1'b1, 2'd3, 12'h03C, 32'hCAFEF00D, 32'h0},
    '{1'b0, 2'd2, 12'h03C, 32'h0,        32'hCAFEF00D},
    '{1'b0, 2'd2, 12'h040, 32'h0,        32'h00000000},
    '{1'b1, 2'd0, 12'h03F, 32'h00000055, 32'h0},
    '{1'b0, 2'd2, 12'h03C, 32'h0,        32'h55FEF00D}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic cpl(input logic [1:0] st, input logic [31:0] d);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_status = st; cpl_data = d;
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base;
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = 3'd0; reg_wdata = '0;
    cpl_valid = 1'b0; cpl_status = '0; cpl_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R4, R8)
    rd(3'd3, v); check("R4 reset status", v, 32'h0);
    rd(3'd4, v); check("R8 reset timeout limit", v, 32'd1000);
    check("R2 reset req_valid", {31'h0, req_valid}, 32'h0);

    // local header table (R10, R11, R12)
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, {20'h00000, TBL[i].off});
      if (TBL[i].wr) wr(3'd2, TBL[i].data);
      wr(3'd1, 32'h8000_0000 | {27'h0, TBL[i].wr, 2'b00, TBL[i].size});
      if (!TBL[i].wr) begin
        rd(3'd2, v);
        check($sformatf("R10/R11/R12 vector %0d", i), v, TBL[i].exp);
      end
    end
    check("R10 local access sends no request", req_cnt, 0);

    // remote Type 0 read (R1, R2, R4, R5)
    wr(3'd0, 32'h011A_0013);
    wr(3'd1, 32'h8000_0000);
    check("R2 req_valid", {31'h0, req_valid}, 32'h1);
    check("R1 req_addr", req_addr, 32'h011A_0010);
    check("R2 type0 read", {30'h0, req_type1, req_write}, 32'h0);
    rd(3'd3, v); check("R4 busy set", v, 32'h1);
    wr(3'd0, 32'hFFFF_FFFF);
    check("R2 single strobe", {31'h0, req_valid}, 32'h0);
    rd(3'd0, v); check("R4 address write ignored while busy", v, 32'h011A_0013);
    cpl(2'd0, 32'hDEAD_BEEF);
    rd(3'd2, v); check("R5 read data", v, 32'hDEAD_BEEF);
    rd(3'd3, v); check("R4 busy cleared", v, 32'h0);

    // remote Type 1 write, unsupported request (R2, R6, R7)
    wr(3'd0, 32'h0200_0004);
    wr(3'd2, 32'h1357_9BDF);
    wr(3'd1, 32'h8000_0110);
    check("R2 type1 write", {30'h0, req_type1, req_write}, 32'h3);
    check("R2 payload", req_data, 32'h1357_9BDF);
    cpl(2'd1, 32'h0);
    rd(3'd3, v); check("R6 UR flag", v, 32'h10);
    rd(3'd2, v); check("R7 failed write keeps data", v, 32'h1357_9BDF);
    wr(3'd3, 32'h10);
    rd(3'd3, v); check("R6 write-one clear", v, 32'h0);

    // remote read aborted (R6, R7)
    wr(3'd1, 32'h8000_0000);
    cpl(2'd2, 32'h1111_1111);
    rd(3'd3, v); check("R6 abort flag", v, 32'h20);
    rd(3'd2, v); check("R7 failed read all ones", v, 32'hFFFF_FFFF);
    wr(3'd3, 32'hF0);

    // timeout (R8)
    wr(3'd2, 32'h0);
    wr(3'd4, 32'd5);
    wr(3'd1, 32'h8000_0000);
    repeat (4) @(negedge clk);
    rd(3'd3, v); check("R8 busy before limit", v, 32'h1);
    @(negedge clk);
    rd(3'd3, v); check("R8 timeout flag", v, 32'h40);
    rd(3'd2, v); check("R8 timed-out read all ones", v, 32'hFFFF_FFFF);
    wr(3'd3, 32'hF0);

    // root bus nonzero device (R9)
    base = req_cnt;
    wr(3'd2, 32'h0);
    wr(3'd0, 32'h0028_0000);
    wr(3'd1, 32'h8000_0000);
    @(negedge clk);
    check("R9 no request", req_cnt, base);
    rd(3'd3, v); check("R9 device-not-found flag", v, 32'h80);
    rd(3'd2, v); check("R9 read all ones", v, 32'hFFFF_FFFF);

    // control without send, then zero (R3)
    wr(3'd0, 32'h0300_0000);
    wr(3'd1, 32'h0000_0100);
    @(negedge clk);
    check("R3 no request without send", req_cnt, base);
    rd(3'd1, v); check("R3 control readback", v, 32'h0000_0100);
    wr(3'd1, 32'h0);
    rd(3'd1, v); check("R3 control cleared", v, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule